// File: doc/BRIEF.md
# Sector Memory Protection Checker

This block stands between a command front end and a serial flash controller and decides, per request, whether a digital read, write, sector-range erase or whole-chip erase may go ahead. Memory is organised in 4 KiB sectors. The sector index of a byte address is the address shifted right by 12.

Two configuration inputs drive the decision. One is a header byte whose upper five bits carry a fixed signature and whose lower three bits turn on read, write and chip-erase locks. The other is a protection pointer that marks where the protected low region of memory ends.

A request enters on a valid/ready channel. It carries an operation code, a start byte address and an end byte address. The verdict leaves on its own valid/ready channel. For a granted sector-range erase, a third valid/ready channel emits each sector index to erase, in ascending order. That sector stream starts in the same cycle as the verdict.

Back-pressure rules:
- A new request is taken only when neither output channel holds anything.
- A verdict stays valid and unchanged until `rsp_ready` is seen high.
- Each erase sector index stays valid and unchanged until `ers_ready` is seen high.
- The two output channels are independent, so either may stall while the other drains.

Top module: `sect_guard`

## Requirements
- R1: The header is valid only when bits 7:3 equal 5'b11001. For any other value `hdr_bad` is 1 and no lock applies to any request.
- R2: With a valid header, the protected region is every sector whose index is below `prot_ptr`, so a pointer of 0 protects nothing. A locked request is refused with code 2'b01 if its range touches at least one protected sector, even when the rest of the range lies outside the region.
- R3: Operation code 2'b00 is a read. Reads are locked when header bit 2 is 0.
- R4: Operation code 2'b01 is a write and 2'b10 is a sector-range erase. Both are locked when header bit 1 is 0.
- R5: Operation code 2'b11 is a chip erase. It ignores both addresses and the pointer, and it is refused with code 2'b01 exactly when the header is valid and bit 0 is 0.
- R6: For operation codes 2'b00, 2'b01 and 2'b10, an end sector below the start sector is refused with code 2'b10.
- R7: A write whose end sector is at or above WR_LIMIT_SECT is refused with code 2'b10. The default is 2048 sectors, which is 8 MiB. Address refusals take priority over lock refusals. Code 2'b00 means granted.
- R8: A granted sector-range erase emits every sector index from the start sector to the end sector, ascending, once each. Every other outcome or operation emits no sector.
- R9: `req_ready` is high only while no verdict and no erase sector is outstanding. `rsp_code` holds until accepted, and `ers_sector` holds until accepted.
- R10: After reset, `req_ready` is 1 and both `rsp_valid` and `ers_valid` are 0.
- R11: The verdict, and the first sector of a granted range erase, are valid in the cycle right after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_byte | input | 8 | Protection header byte: signature and three lock bits |
| prot_ptr | input | PTR_W | First sector index outside the protected region |
| hdr_bad | output | 1 | Header signature mismatch |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | Operation code |
| req_start | input | ADDR_W | Start byte address |
| req_end | input | ADDR_W | End byte address |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Verdict taken |
| rsp_code | output | 2 | 00 grant, 01 protection error, 10 address error |
| ers_valid | output | 1 | Erase sector present |
| ers_ready | input | 1 | Erase sector taken |
| ers_sector | output | ADDR_W-SECT_SHIFT | Sector index to erase |

## Verification
The verdict hand-off and the first erase-sector hand-off of a granted range erase can fall in the same cycle, because both channels turn valid together. The bench drives `rsp_ready` and `ers_ready` with two different periodic patterns, so the two channels accept sometimes together and sometimes apart. In every case the bench checks that the verdict is taken exactly once and that the sector sequence arrives complete and ordered, whichever channel drains first. It also counts the cycles where both hand-offs coincide, and requires that count to be nonzero.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_SERASE = 2'b10,
    OP_CERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    RC_GRANT = 2'b00,
    RC_PROT  = 2'b01,
    RC_ADDR  = 2'b10
  } rc_e;

  localparam logic [4:0] HDR_SIG = 5'b11001;

  typedef struct packed {
    logic valid;
    logic lock_rd;
    logic lock_wr;
    logic lock_ce;
  } guard_t;

endpackage

// File: rtl/sg_hdr_decode.sv
module sg_hdr_decode
  import sg_pkg::*;
(
  input  logic [7:0] hdr_byte,
  output guard_t     guard
);

  logic sig_ok;

  // Signature sits in the upper five bits; locks are active when their bit is cleared.
  assign sig_ok        = (hdr_byte[7:3] == HDR_SIG);
  assign guard.valid   = sig_ok;
  assign guard.lock_rd = sig_ok & ~hdr_byte[2];
  assign guard.lock_wr = sig_ok & ~hdr_byte[1];
  assign guard.lock_ce = sig_ok & ~hdr_byte[0];

endmodule

// File: rtl/sg_rule_eval.sv
module sg_rule_eval
  import sg_pkg::*;
#(
  parameter int SECT_W        = 12,
  parameter int PTR_W         = 16,
  parameter int WR_LIMIT_SECT = 2048
) (
  input  op_e               op,
  input  logic [SECT_W-1:0] s_sec,
  input  logic [SECT_W-1:0] e_sec,
  input  logic [PTR_W-1:0]  ptr,
  input  guard_t            guard,
  output rc_e               code
);

  logic [31:0] s_ext, e_ext, p_ext;
  logic        reversed, over_limit, touches, locked;

  assign s_ext = 32'(s_sec);
  assign e_ext = 32'(e_sec);
  assign p_ext = 32'(ptr);

  assign reversed   = (e_ext < s_ext);
  assign over_limit = (op == OP_WRITE) && (e_ext >= 32'(WR_LIMIT_SECT));
  // The region starts at sector zero, so a range touches it exactly when its start does.
  assign touches    = (s_ext < p_ext);
  assign locked     = (op == OP_READ) ? guard.lock_rd : guard.lock_wr;

  always_comb begin
    if (op == OP_CERASE) begin
      code = guard.lock_ce ? RC_PROT : RC_GRANT;
    end else if (reversed || over_limit) begin
      code = RC_ADDR;
    end else if (touches && locked) begin
      code = RC_PROT;
    end else begin
      code = RC_GRANT;
    end
  end

endmodule

// File: rtl/sg_erase_seq.sv
module sg_erase_seq #(
  parameter int SECT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SECT_W-1:0] first,
  input  logic [SECT_W-1:0] last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SECT_W-1:0] sector
);

  logic [SECT_W-1:0] cur_q, last_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cur_q   <= '0;
      last_q  <= '0;
    end else if (start) begin
      valid_q <= 1'b1;
      cur_q   <= first;
      last_q  <= last;
    end else if (valid_q && out_ready) begin
      if (cur_q == last_q) valid_q <= 1'b0;
      else                 cur_q   <= cur_q + 1'b1;
    end
  end

  assign out_valid = valid_q;
  assign sector    = cur_q;

  assert_ers_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(sector));

  assert_ers_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (sector != last_q) |=> out_valid && (sector == $past(sector) + 1'b1));

endmodule

// File: rtl/sect_guard.sv
module sect_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int SECT_SHIFT    = 12,
  parameter int PTR_W         = 16,
  parameter int WR_LIMIT_SECT = 2048,
  localparam int SECT_W       = ADDR_W - SECT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        hdr_byte,
  input  logic [PTR_W-1:0]  prot_ptr,
  output logic              hdr_bad,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_code,
  output logic              ers_valid,
  input  logic              ers_ready,
  output logic [SECT_W-1:0] ers_sector
);

  guard_t            guard;
  rc_e               verdict;
  op_e               op_in;
  logic [SECT_W-1:0] s_sec, e_sec;
  logic              accept, ers_start;

  logic rsp_valid_q;
  rc_e  code_q;
  op_e  op_q;

  assign op_in = op_e'(req_op);
  assign s_sec = req_start[ADDR_W-1:SECT_SHIFT];
  assign e_sec = req_end[ADDR_W-1:SECT_SHIFT];

  sg_hdr_decode u_hdr (
    .hdr_byte (hdr_byte),
    .guard    (guard)
  );

  sg_rule_eval #(
    .SECT_W        (SECT_W),
    .PTR_W         (PTR_W),
    .WR_LIMIT_SECT (WR_LIMIT_SECT)
  ) u_rule (
    .op    (op_in),
    .s_sec (s_sec),
    .e_sec (e_sec),
    .ptr   (prot_ptr),
    .guard (guard),
    .code  (verdict)
  );

  assign req_ready = !rsp_valid_q && !ers_valid;
  assign accept    = req_valid && req_ready;
  assign ers_start = accept && (verdict == RC_GRANT) && (op_in == OP_SERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      code_q      <= RC_GRANT;
      op_q        <= OP_READ;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      code_q      <= verdict;
      op_q        <= op_in;
    end else if (rsp_valid_q && rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  sg_erase_seq #(
    .SECT_W (SECT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ers_start),
    .first     (s_sec),
    .last      (e_sec),
    .out_valid (ers_valid),
    .out_ready (ers_ready),
    .sector    (ers_sector)
  );

  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = code_q;
  assign hdr_bad   = !guard.valid;

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code));

  assert_rsp_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  assert_ers_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ers_valid |-> (op_q == OP_SERASE) && (code_q == RC_GRANT));

  assert_hdr_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_bad |-> !guard.lock_rd && !guard.lock_wr && !guard.lock_ce);

endmodule

// File: tb/sect_guard_bench.sv
module sect_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int SS  = 12;
  localparam int PW  = 5;
  localparam int LIM = 12;
  localparam int SW  = AW - SS;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    hdr_byte = 8'hCF;
  logic [PW-1:0] prot_ptr = '0;
  logic          hdr_bad;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_start = '0;
  logic [AW-1:0] req_end = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [1:0]    rsp_code;
  logic          ers_valid;
  logic          ers_ready = 1'b0;
  logic [SW-1:0] ers_sector;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int both_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sect_guard #(
    .ADDR_W (AW), .SECT_SHIFT (SS), .PTR_W (PW), .WR_LIMIT_SECT (LIM)
  ) u_sect_guard (
    .clk (clk), .rst_n (rst_n), .hdr_byte (hdr_byte), .prot_ptr (prot_ptr),
    .hdr_bad (hdr_bad), .req_valid (req_valid), .req_ready (req_ready),
    .req_op (req_op), .req_start (req_start), .req_end (req_end),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_code (rsp_code),
    .ers_valid (ers_valid), .ers_ready (ers_ready), .ers_sector (ers_sector)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycle=%0d expected below %0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected verdict from R1..R7.
  function automatic int exp_code(int op, int s, int e, int ptr, logic [7:0] h);
    bit ok_sig = (h[7:3] == 5'b11001);
    if (op == 3) return (ok_sig && !h[0]) ? 1 : 0;              // R5
    if (e < s || (op == 1 && e >= LIM)) return 2;               // R6, R7
    if (s < ptr && ok_sig && ((op == 0 && !h[2]) || (op != 0 && !h[1]))) return 1; // R2, R3, R4
    return 0;
  endfunction

  task automatic run_req(input int op, input int s, input int e, input int ptr, input logic [7:0] h);
    int code_seen = -1;
    int n = 0;
    int next_exp = s;
    int guard_cnt = 0;
    bit seq_ok = 1'b1;
    bit got = 1'b0;
    int ec = exp_code(op, s, e, ptr, h);
    int en = (ec == 0 && op == 2) ? (e - s + 1) : 0;
    int off = (s * 251 + e * 73 + op * 11) % 4096;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_start = {4'(s), 12'(off)};
    req_end   = {4'(e), 12'(4095 - off)};
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R11 verdict next cycle", int'(rsp_valid), 1);
    while ((!got || ers_valid) && guard_cnt < 200) begin
      rsp_ready = (cyc % 4) != 2;
      ers_ready = (cyc % 3) != 1;
      if (rsp_valid && rsp_ready && !got) begin
        got = 1'b1;
        code_seen = int'(rsp_code);
        if (ers_valid && ers_ready) both_cnt++;
      end
      if (ers_valid && ers_ready) begin
        if (int'(ers_sector) != next_exp) seq_ok = 1'b0;
        next_exp++;
        n++;
      end
      @(negedge clk);
      guard_cnt++;
    end
    check(code_seen == ec, "R2-verdict (R3 R4 R5 R6 R7)", code_seen, ec);
    check(n == en && seq_ok, "R8 erase sector sequence count", n, en);
  endtask

  initial begin
    logic [7:0] hdrs [5];
    int ptrs [3];
    hdrs[0] = 8'hCF; hdrs[1] = 8'hC8; hdrs[2] = 8'hCA; hdrs[3] = 8'hCD; hdrs[4] = 8'h48;
    ptrs[0] = 0; ptrs[1] = 5; ptrs[2] = 16;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R10 reset req_ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R10 reset rsp_valid", int'(rsp_valid), 0);
    check(ers_valid == 1'b0, "R10 reset ers_valid", int'(ers_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int hi = 0; hi < 5; hi++) begin
      hdr_byte = hdrs[hi];
      #1;
      check(hdr_bad == (hdrs[hi][7:3] != 5'b11001), "R1 header signature",
            int'(hdr_bad), int'(hdrs[hi][7:3] != 5'b11001));
      for (int pi = 0; pi < 3; pi++) begin
        prot_ptr = PW'(ptrs[pi]);
        for (int op = 0; op < 4; op++)
          for (int s = 0; s < 16; s++)
            for (int e = 0; e < 16; e++)
              run_req(op, s, e, ptrs[pi], hdrs[hi]);
      end
    end
    check(both_cnt > 0, "R11 verdict and erase accepted together", both_cnt, 1);
    check(req_ready == 1'b1 && !ers_valid, "R9 idle after sweep", int'(req_ready), 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule